// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Atomic Set/Clear

This block is a general-purpose I/O port that sits on a simple synchronous register bus. The bus carries an address, a write strobe, write data, a read strobe and read data. Every line of the port drives a tri-state pad model made of an output value, an output enable and an input level. The port has one line for each bit of the register width.

Software can load the whole output latch at once through the pins register. It can also raise or lower chosen lines through the set and clear masks, which need no read-modify-write. Line direction lives in one shared state. That state can be written in either polarity: through an output-direction view, where 1 means output, or through an input-direction view, where 1 means input. The two views therefore always read back as complements.

Pin levels pass through a two-flop synchronizer before software can read them. The set register reads back what the latch drives. A parameter can mirror the bit numbering, so that line n lives in register bit WIDTH-1-n.

Top module: `mmio_gpio`

## Requirements
- R1: A write to the pins register (word address 0) loads the output latch with the written word. From the next clock edge, pad_out carries the latch for every line, whatever the line's direction.
- R2: A write to the set register (address 1) drives high every latch bit written as 1. Bits written as 0 keep their value.
- R3: A write to the clear register (address 2) drives low every latch bit written as 1. Bits written as 0 keep their value.
- R4: A write to the output-direction register (address 3) makes each line whose bit is 1 an output and each line whose bit is 0 an input. pad_oe is high exactly for the output lines.
- R5: A write to the input-direction register (address 4) makes each line whose bit is 1 an input and each line whose bit is 0 an output. Reads of addresses 3 and 4 always return bitwise complements of each other.
- R6: A read of the pins register returns the pad_in levels after a two-flop synchronizer. A change of pad_in that is present before clock edge k is returned by a read whose request is sampled at edge k+2. Reads sampled at edges k and k+1 still return the old level.
- R7: A read of the set register returns the current output latch. A read of the clear register returns zero.
- R8: With MIRROR=1, line n corresponds to bit WIDTH-1-n in every register, on writes and on reads alike. With MIRROR=0, line n is bit n.
- R9: While rst is high, all lines become inputs, the latch clears and bus_rdata reads zero.
- R10: bus_rdata holds the read result in the cycle after a read request is sampled, and is zero after any edge at which no read was requested.
- R11: Direction writes never change the output latch.
- R12: Writes to unmapped addresses (5 to 7) change no state. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Registered read data |
| pad_out | output | WIDTH | Output value for each line |
| pad_oe | output | WIDTH | Output enable for each line |
| pad_in | input | WIDTH | Sampled level of each pad |

## Verification
The assertions assume that bus_we and bus_re are never high in the same cycle, and that the address holds a known value whenever either strobe is high. They also assume that pad_in carries no unknown values once reset ends. The bench drives each access from a task that raises one strobe for exactly one cycle and clears it before the next access begins. The pad model in the bench always resolves pad_in to a known level, taking the latch value on output lines and a bench-chosen level on input lines.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS = 3'd0,
    REG_SET  = 3'd1,
    REG_CLR  = 3'd2,
    REG_ODIR = 3'd3,
    REG_IDIR = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic load;
    logic set;
    logic clr;
    logic odir;
    logic idir;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_bitorder.sv
module gpio_bitorder #(
  parameter int unsigned WIDTH  = 32,
  parameter bit          MIRROR = 1'b0
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (MIRROR) begin : g_mirror
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = din[WIDTH-1-i];
      end
    end else begin : g_straight
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_core.sv
module gpio_core
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_strobe_t       wr,
  input  logic [WIDTH-1:0] wmask,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] dir_d;

  always_comb begin
    latch_d = latch_q;
    if (wr.load)     latch_d = wmask;
    else if (wr.set) latch_d = latch_q | wmask;
    else if (wr.clr) latch_d = latch_q & ~wmask;
  end

  always_comb begin
    dir_d = dir_q;
    if (wr.odir)      dir_d = wmask;
    else if (wr.idir) dir_d = ~wmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

  AST_SET_RAISES_ONLY: assert property (@(posedge clk) disable iff (rst)
    $past(wr.set) && !$past(wr.load) |->
      ((latch_q & $past(wmask)) == $past(wmask)) &&
      ((latch_q & ~$past(wmask)) == ($past(latch_q) & ~$past(wmask)))); // R2
  AST_CLR_LOWERS_ONLY: assert property (@(posedge clk) disable iff (rst)
    $past(wr.clr) && !$past(wr.set) && !$past(wr.load) |->
      ((latch_q & $past(wmask)) == '0) &&
      ((latch_q & ~$past(wmask)) == ($past(latch_q) & ~$past(wmask)))); // R3
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(wr.odir) && !$past(wr.idir) |-> $stable(dir_q)); // R4
  AST_DIR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (rst)
    ($past(wr.odir) || $past(wr.idir)) && !$past(wr.load) && !$past(wr.set) &&
    !$past(wr.clr) |-> $stable(latch_q)); // R11
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (latch_q == '0) && (dir_q == '0)); // R9
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WIDTH-1:0]  pins,
  input  logic [WIDTH-1:0]  latch,
  input  logic [WIDTH-1:0]  dir,
  output logic [WIDTH-1:0]  rdata_q
);
  logic [WIDTH-1:0] sel;

  always_comb begin
    unique case (rd_addr)
      REG_PINS: sel = pins;
      REG_SET:  sel = latch;
      REG_ODIR: sel = dir;
      REG_IDIR: sel = ~dir;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel;
    else            rdata_q <= '0;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rdata_q == '0); // R10
  AST_RD_SET_IS_LATCH: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) && ($past(rd_addr) == REG_SET) |-> rdata_q == $past(latch)); // R7
endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter bit          MIRROR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_re,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  pad_in
);
  localparam int unsigned SYNC_STAGES = 2;

  wr_strobe_t       wr;
  logic [WIDTH-1:0] wmask_line;
  logic [WIDTH-1:0] latch_line;
  logic [WIDTH-1:0] dir_line;
  logic [WIDTH-1:0] pins_line;
  logic [WIDTH-1:0] rdata_line;

  always_comb begin
    wr      = '0;
    wr.load = bus_we && (bus_addr == REG_PINS);
    wr.set  = bus_we && (bus_addr == REG_SET);
    wr.clr  = bus_we && (bus_addr == REG_CLR);
    wr.odir = bus_we && (bus_addr == REG_ODIR);
    wr.idir = bus_we && (bus_addr == REG_IDIR);
  end

  gpio_bitorder #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_wr_order (
    .din  (bus_wdata),
    .dout (wmask_line)
  );

  gpio_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr),
    .wmask   (wmask_line),
    .latch_q (latch_line),
    .dir_q   (dir_line)
  );

  gpio_insync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pins_line)
  );

  gpio_rdmux #(.WIDTH(WIDTH)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_re),
    .rd_addr (bus_addr),
    .pins    (pins_line),
    .latch   (latch_line),
    .dir     (dir_line),
    .rdata_q (rdata_line)
  );

  gpio_bitorder #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_rd_order (
    .din  (rdata_line),
    .dout (bus_rdata)
  );

  assign pad_out = latch_line;
  assign pad_oe  = dir_line;

  AST_UNMAPPED_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
    $past(bus_we) && ($past(bus_addr) > REG_IDIR) |->
      $stable(pad_out) && $stable(pad_oe)); // R12
  AST_LOAD_REACHES_PAD: assert property (@(posedge clk) disable iff (rst)
    $past(wr.load) |-> pad_out == $past(wmask_line)); // R1
endmodule

// File: tb/sim_mmio_gpio.sv
module sim_mmio_gpio;
  localparam int W0 = 32;
  localparam int W1 = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]    a0;
  logic          we0;
  logic          re0;
  logic [W0-1:0] wd0;
  logic [W0-1:0] rd0;
  logic [W0-1:0] po0;
  logic [W0-1:0] oe0;
  logic [W0-1:0] pi0;
  logic [W0-1:0] ext0;

  logic [2:0]    a1;
  logic          we1;
  logic          re1;
  logic [W1-1:0] wd1;
  logic [W1-1:0] rd1;
  logic [W1-1:0] po1;
  logic [W1-1:0] oe1;
  logic [W1-1:0] pi1;
  logic [W1-1:0] ext1;

  assign pi0 = (oe0 & po0) | (~oe0 & ext0);
  assign pi1 = (oe1 & po1) | (~oe1 & ext1);

  mmio_gpio #(.WIDTH(W0), .MIRROR(1'b0)) u0 (
    .clk(clk), .rst(rst), .bus_addr(a0), .bus_we(we0), .bus_wdata(wd0),
    .bus_re(re0), .bus_rdata(rd0), .pad_out(po0), .pad_oe(oe0), .pad_in(pi0));

  mmio_gpio #(.WIDTH(W1), .MIRROR(1'b1)) u1 (
    .clk(clk), .rst(rst), .bus_addr(a1), .bus_we(we1), .bus_wdata(wd1),
    .bus_re(re1), .bus_rdata(rd1), .pad_out(po1), .pad_oe(oe1), .pad_in(pi1));

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr0(input logic [2:0] adr, input logic [W0-1:0] d);
    a0 = adr; wd0 = d; we0 = 1'b1;
    @(negedge clk);
    we0 = 1'b0;
  endtask

  task automatic rdq0(input logic [2:0] adr, output logic [W0-1:0] d);
    a0 = adr; re0 = 1'b1;
    @(negedge clk);
    re0 = 1'b0;
    d = rd0;
  endtask

  task automatic wr1(input logic [2:0] adr, input logic [W1-1:0] d);
    a1 = adr; wd1 = d; we1 = 1'b1;
    @(negedge clk);
    we1 = 1'b0;
  endtask

  task automatic rdq1(input logic [2:0] adr, output logic [W1-1:0] d);
    a1 = adr; re1 = 1'b1;
    @(negedge clk);
    re1 = 1'b0;
    d = rd1;
  endtask

  task automatic t_reset();
    logic [W0-1:0] v;
    chk("R9 rdata in reset", rd0, '0);
    chk("R9 oe in reset", oe0, '0);
    chk("R9 latch in reset", po0, '0);
    rst = 1'b0;
    @(negedge clk);
    rdq0(3'd3, v); chk("R9 outdir after reset", v, '0);
    rdq0(3'd4, v); chk("R5 indir after reset", v, {W0{1'b1}});
    @(negedge clk);
    chk("R10 idle rdata", rd0, '0);
  endtask

  task automatic t_load_set_clear();
    logic [W0-1:0] v;
    wr0(3'd0, 32'hA5A5_0F0F);
    chk("R1 pad_out after load (input lines)", po0, 32'hA5A5_0F0F);
    rdq0(3'd1, v); chk("R7 set readback", v, 32'hA5A5_0F0F);
    wr0(3'd1, 32'h0000_00F0);
    chk("R2 set mask", po0, 32'hA5A5_0FFF);
    wr0(3'd1, 32'h0000_0000);
    chk("R2 zero set mask", po0, 32'hA5A5_0FFF);
    wr0(3'd2, 32'h8000_0F00);
    chk("R3 clear mask", po0, 32'h25A5_00FF);
    wr0(3'd2, 32'h0000_0000);
    chk("R3 zero clear mask", po0, 32'h25A5_00FF);
    rdq0(3'd2, v); chk("R7 clear reads zero", v, '0);
  endtask

  task automatic t_direction();
    logic [W0-1:0] v;
    wr0(3'd3, 32'hFFFF_0000);
    chk("R4 pad_oe from outdir", oe0, 32'hFFFF_0000);
    rdq0(3'd4, v); chk("R5 indir complement", v, 32'h0000_FFFF);
    wr0(3'd4, 32'h0000_00FF);
    chk("R5 pad_oe from indir", oe0, 32'hFFFF_FF00);
    rdq0(3'd3, v); chk("R5 outdir view", v, 32'hFFFF_FF00);
    chk("R11 latch kept over dir writes", po0, 32'h25A5_00FF);
  endtask

  task automatic t_pins_sync();
    logic [W0-1:0] v;
    logic [W0-1:0] oldv;
    logic [W0-1:0] newv;
    ext0 = 32'h1234_5678;
    repeat (3) @(negedge clk);
    oldv = (32'hFFFF_FF00 & 32'h25A5_00FF) | (32'h0000_00FF & 32'h1234_5678);
    rdq0(3'd0, v); chk("R6 mixed-direction pins read", v, oldv);
    ext0 = 32'h0000_00A3;
    newv = (32'hFFFF_FF00 & 32'h25A5_00FF) | 32'h0000_00A3;
    rdq0(3'd0, v); chk("R6 edge k still old", v, oldv);
    rdq0(3'd0, v); chk("R6 edge k+1 still old", v, oldv);
    rdq0(3'd0, v); chk("R6 edge k+2 new", v, newv);
  endtask

  task automatic t_unmapped();
    logic [W0-1:0] v;
    wr0(3'd6, {W0{1'b1}});
    wr0(3'd5, {W0{1'b1}});
    chk("R12 latch unchanged", po0, 32'h25A5_00FF);
    chk("R12 dir unchanged", oe0, 32'hFFFF_FF00);
    rdq0(3'd7, v); chk("R12 unmapped read zero", v, '0);
  endtask

  task automatic t_mirror();
    logic [W1-1:0] v;
    wr1(3'd1, 8'h01);
    chk("R8 set bit0 drives line 7", po1, 8'h80);
    wr1(3'd3, 8'h03);
    chk("R8 outdir bits0-1 enable lines 7-6", oe1, 8'hC0);
    rdq1(3'd1, v); chk("R8 set readback mirrored", v, 8'h01);
    ext1 = 8'h02;
    repeat (3) @(negedge clk);
    rdq1(3'd0, v); chk("R8 pins read mirrored", v, 8'h41);
    wr1(3'd2, 8'h01);
    chk("R8 clear bit0 lowers line 7", po1, 8'h00);
  endtask

  initial begin
    a0 = '0; we0 = 1'b0; re0 = 1'b0; wd0 = '0; ext0 = '0;
    a1 = '0; we1 = 1'b0; re1 = 1'b0; wd1 = '0; ext1 = '0;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_set_clear();
    t_direction();
    t_pins_sync();
    t_unmapped();
    t_mirror();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule